// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a small byte-wide flash array. Software issues byte commands through a synchronous write port. The decoded command selects what later reads return: array contents, a pair of identifier bytes, or a status byte. Two-step command sequences start an automated byte program or a block erase. The array itself is a behavioural register file of equal blocks. Program and erase durations are modelled by cycle counters whose lengths are set by parameters.

An erase can be paused and then continued. While it is paused, other blocks can be read. An active-low power-down input aborts any operation in progress and returns the controller to its initial state. After that input is released, a settable number of cycles must pass before commands are taken again. The ready output tells the host when it may poll or issue new work.

Top module: `flash_cmd_fsm`

## Requirements
- R1: While `pd_n` is low, any program or erase is halted and `ready` is 1. Once `pd_n` is high again, the controller is in array-read mode and the status byte reads 80h.
- R2: For the first WAKE_CYC rising edges after `pd_n` returns high, writes on the command port are ignored.
- R3: A command byte FFh selects array-read mode. In that mode a read (`re` high at a clock edge) puts the addressed array byte on `rdata` at that edge.
- R4: A command byte 90h selects identifier mode. Reads at address 0 return 89h, reads at address 1 return A2h, and reads at any other address return 00h.
- R5: A command byte 70h selects status mode. The status byte has these fields: bit 7 is 1 when no operation is running (or when the running erase is paused), bit 6 is erase-paused, bit 5 is erase error, bit 4 is program error, and bits 3..0 are always 0.
- R6: A command byte 50h clears status bits 5 and 4.
- R7: Writing 20h and then D0h erases the block selected by the top NBLK_W address bits of the 20h write, setting every byte of that block to FFh. `ready` is low for exactly ERASE_CYC cycles.
- R8: Writing 40h or 10h and then a data byte D at address A programs A. The new value is the old value AND D. `ready` is low for exactly PROG_CYC cycles.
- R9: If 20h is followed by any byte other than D0h, status bits 5 and 4 are set and no erase takes place.
- R10: Writing B0h during an erase pauses it. `ready` goes high, status reads C0h, and other blocks can be read in array mode. A later D0h resumes the erase, which then completes.
- R11: In idle mode, a command byte outside {FFh, 90h, 70h, 50h, 20h, 40h, 10h} changes neither the read mode nor the status byte, and starts no operation.
- R12: After a program or erase starts, reads return the status byte until FFh is written.
- R13: Driving `pd_n` low during a program leaves every other array byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pd_n | input | 1 | Active-low power-down and reset |
| addr | input | NBLK_W+BOFF_W | Byte address for commands and reads |
| wdata | input | 8 | Command or program data byte |
| we | input | 1 | Write strobe, sampled at the clock edge |
| re | input | 1 | Read strobe; rdata updates at this edge |
| rdata | output | 8 | Read result (array, identifier or status) |
| ready | output | 1 | High unless a program or erase is actively running |

## Verification
The embedded properties check the following on every cycle:
- writes are ignored during the wake-up window;
- a broken erase sequence sets both error bits and starts nothing;
- a paused erase keeps its remaining time frozen;
- reserved codes issued in idle change no mode, pending or error state;
- every operation starts with status reads selected.

Only the bench scenarios can show the data results:
- the AND rule for programming;
- whole-block erase, including erase after resume;
- the identifier bytes;
- the exact busy durations;
- array contents surviving an aborted program.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int NBLK_W    = 4,
  parameter int BOFF_W    = 2,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 40,
  parameter int WAKE_CYC  = 8,
  localparam int AW    = NBLK_W + BOFF_W,
  localparam int DEPTH = 1 << AW,
  localparam int BSZ   = 1 << BOFF_W,
  localparam int CW    = $clog2(ERASE_CYC + PROG_CYC + WAKE_CYC + 1)
) (
  input  logic          clk,
  input  logic          pd_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          we,
  input  logic          re,
  output logic [7:0]    rdata,
  output logic          ready
);
  typedef enum logic [1:0] {M_ARR, M_ID, M_STAT} mode_t;

  logic [7:0]    mem [DEPTH];
  mode_t         mode;
  logic          pend_e, pend_w, run_e, run_w, susp, eerr, werr;
  logic [AW-1:0] padr;
  logic [7:0]    pdat;
  logic [CW-1:0] cnt, wake;

  wire awake  = (wake == '0);
  wire cmd    = we && awake;
  wire busy   = (run_e || run_w) && !susp;
  wire finish = busy && (cnt == '0);
  wire [7:0] status = {!busy, susp, eerr, werr, 4'b0};
  assign ready = !busy;

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) begin
      mode <= M_ARR;  pend_e <= 1'b0; pend_w <= 1'b0;
      run_e <= 1'b0;  run_w <= 1'b0;  susp <= 1'b0;
      eerr <= 1'b0;   werr <= 1'b0;
      padr <= '0;     pdat <= '0;     cnt <= '0;
      wake <= CW'(WAKE_CYC);
    end else begin
      if (!awake) wake <= wake - 1'b1;
      if (busy) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        else begin run_e <= 1'b0; run_w <= 1'b0; end
      end
      if (cmd) begin
        if (pend_e) begin
          pend_e <= 1'b0;
          mode   <= M_STAT;
          if (wdata == 8'hD0) begin
            run_e <= 1'b1;
            cnt   <= CW'(ERASE_CYC - 1);
          end else begin
            eerr <= 1'b1;
            werr <= 1'b1;
          end
        end else if (pend_w) begin
          pend_w <= 1'b0;
          mode   <= M_STAT;
          run_w  <= 1'b1;
          cnt    <= CW'(PROG_CYC - 1);
          padr   <= addr;
          pdat   <= wdata;
        end else if (busy) begin
          if (wdata == 8'h70) mode <= M_STAT;
          else if (wdata == 8'hB0 && run_e && cnt != '0) susp <= 1'b1;
        end else if (susp) begin
          case (wdata)
            8'hD0:   begin susp <= 1'b0; mode <= M_STAT; end
            8'hFF:   mode <= M_ARR;
            8'h90:   mode <= M_ID;
            8'h70:   mode <= M_STAT;
            default: ;
          endcase
        end else begin
          case (wdata)
            8'hFF:        mode <= M_ARR;
            8'h90:        mode <= M_ID;
            8'h70:        mode <= M_STAT;
            8'h50:        begin eerr <= 1'b0; werr <= 1'b0; end
            8'h20:        begin pend_e <= 1'b1; padr <= addr; end
            8'h40, 8'h10: pend_w <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (finish && run_w) mem[padr] <= mem[padr] & pdat;
    if (finish && run_e)
      for (int b = 0; b < BSZ; b++)
        mem[{padr[AW-1:BOFF_W], BOFF_W'(b)}] <= 8'hFF;
  end

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) rdata <= '0;
    else if (re) begin
      case (mode)
        M_ARR:   rdata <= mem[addr];
        M_ID:    rdata <= (addr == AW'(0)) ? 8'h89 : (addr == AW'(1)) ? 8'hA2 : 8'h00;
        default: rdata <= status;
      endcase
    end
  end

  function automatic logic known_code(input logic [7:0] c);
    return c inside {8'hFF, 8'h90, 8'h70, 8'h50, 8'h20, 8'h40, 8'h10};
  endfunction

  p_wake_ignore_r2: assert property (@(posedge clk) disable iff (!pd_n)
    (!awake && we) |=> $stable(mode) && $stable(pend_e) && $stable(pend_w));

  p_seq_error_r9: assert property (@(posedge clk) disable iff (!pd_n)
    (cmd && pend_e && wdata != 8'hD0) |=> !run_e && eerr && werr);

  p_suspend_freeze_r10: assert property (@(posedge clk) disable iff (!pd_n)
    (susp && !(cmd && wdata == 8'hD0)) |=> susp && $stable(cnt));

  p_reserved_idle_r11: assert property (@(posedge clk) disable iff (!pd_n)
    (cmd && !busy && !susp && !pend_e && !pend_w && !known_code(wdata))
      |=> $stable(mode) && !run_e && !run_w && !pend_e && !pend_w && $stable({eerr, werr}));

  p_start_status_r12: assert property (@(posedge clk) disable iff (!pd_n)
    $rose(run_e || run_w) |-> mode == M_STAT);
endmodule

// File: tb/flash_cmd_fsm_test.sv
module flash_cmd_fsm_test;
  localparam int NBLK_W = 4, BOFF_W = 2, PROG_CYC = 6, ERASE_CYC = 40, WAKE_CYC = 8;
  localparam int AW = NBLK_W + BOFF_W, DEPTH = 1 << AW, BSZ = 1 << BOFF_W;

  logic clk = 1'b0, pd_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic ready;
  int nchk = 0, nfail = 0;
  logic [7:0] model [DEPTH];
  bit done = 1'b0;

  flash_cmd_fsm #(.NBLK_W(NBLK_W), .BOFF_W(BOFF_W), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .WAKE_CYC(WAKE_CYC)) uut (
    .clk(clk), .pd_n(pd_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .ready(ready));

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_id(input int a);
    return (a == 0) ? 8'h89 : (a == 1) ? 8'hA2 : 8'h00;
  endfunction

  function automatic bit is_rsvd(input logic [7:0] c);
    return !(c inside {8'hFF, 8'h90, 8'h70, 8'h50, 8'h20, 8'h40, 8'h10});
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); addr = AW'(a); re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic erase_blk(input int blk, input bit chk_len);
    int n;
    wr(blk * BSZ, 8'h20); wr(blk * BSZ + 1, 8'hD0);
    wait_ready(n);
    if (chk_len) chk("R7 erase busy length", 8'(n), 8'(ERASE_CYC));
    for (int i = 0; i < BSZ; i++) model[blk * BSZ + i] = 8'hFF;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n, a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 ready in power-down", 8'(ready), 8'd1);
    pd_n = 1'b1;
    repeat (WAKE_CYC + 2) @(negedge clk);
    wr(0, 8'h70); rd(0, v); chk("R1/R5 status after reset", v, 8'h80);

    for (int b = 0; b < (1 << NBLK_W); b++) erase_blk(b, b == 0);
    wr(0, 8'hFF);
    for (int i = 0; i < DEPTH; i += 7) begin rd(i, v); chk("R3/R7 erased byte", v, 8'hFF); end

    @(negedge clk); pd_n = 1'b0; @(negedge clk); pd_n = 1'b1;
    wr(0, 8'h90); rd(0, v); chk("R2 command ignored during wake", v, 8'hFF);
    repeat (WAKE_CYC) @(negedge clk);
    wr(0, 8'h90);
    for (int i = 0; i < 4; i++) begin rd(i, v); chk("R4 identifier", v, exp_id(i)); end
    wr(0, 8'hFF);

    for (int it = 0; it < 80; it++) begin
      a = int'($urandom_range(DEPTH - 1));
      if ($urandom_range(3) == 0) begin
        do v = 8'($urandom); while (!is_rsvd(v));
        wr(a, v);
        chk("R11 ready after reserved code", 8'(ready), 8'd1);
        rd(a, v); chk("R11 still array mode", v, model[a]);
      end else begin
        logic [7:0] d;
        d = 8'($urandom);
        wr(a, ($urandom_range(1) != 0) ? 8'h40 : 8'h10);
        wr(a, d);
        wait_ready(n);
        chk("R8 program busy length", 8'(n), 8'(PROG_CYC));
        model[a] = model[a] & d;
        rd(a, v); chk("R12 status after program", v, 8'h80);
        wr(0, 8'hFF);
        rd(a, v); chk("R8 programmed value", v, model[a]);
      end
    end

    wr(9, 8'h20); wr(9, 8'h55);
    chk("R9 no erase started", 8'(ready), 8'd1);
    rd(0, v); chk("R9 error bits set", v, 8'hB0);
    wr(0, 8'h50); wr(0, 8'h70); rd(0, v); chk("R6 error bits cleared", v, 8'h80);
    wr(0, 8'hFF); rd(9, v); chk("R9 block untouched", v, model[9]);

    wr(5 * BSZ + 2, 8'h40); wr(5 * BSZ + 2, 8'h0F); wait_ready(n);
    model[5 * BSZ + 2] = model[5 * BSZ + 2] & 8'h0F;
    wr(5 * BSZ, 8'h20); wr(5 * BSZ, 8'hD0);
    repeat (3) @(negedge clk);
    wr(0, 8'hB0);
    chk("R10 ready while paused", 8'(ready), 8'd1);
    rd(0, v); chk("R10 paused status", v, 8'hC0);
    wr(0, 8'hFF); rd(2 * BSZ + 1, v); chk("R10 read other block while paused", v, model[2 * BSZ + 1]);
    wr(0, 8'hD0);
    chk("R10 busy after resume", 8'(ready), 8'd0);
    wait_ready(n);
    for (int i = 0; i < BSZ; i++) model[5 * BSZ + i] = 8'hFF;
    rd(0, v); chk("R12 status after erase", v, 8'h80);
    wr(0, 8'hFF);
    for (int i = 0; i < BSZ; i++) begin rd(5 * BSZ + i, v); chk("R10 resumed erase done", v, 8'hFF); end

    wr(3 * BSZ + 1, 8'h40); wr(3 * BSZ + 1, 8'h00);
    @(negedge clk); pd_n = 1'b0;
    @(negedge clk);
    chk("R1 ready during power-down abort", 8'(ready), 8'd1);
    pd_n = 1'b1;
    repeat (WAKE_CYC + 1) @(negedge clk);
    rd(3 * BSZ, v); chk("R13 neighbour byte kept", v, model[3 * BSZ]);
    rd(7, v); chk("R13 other byte kept", v, model[7]);
    wr(0, 8'h70); rd(0, v); chk("R1 status after abort", v, 8'h80);
    erase_blk(3, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule